// File: doc/BRIEF.md
# Dual-Master Control and Status Register Bank

This block is a small register bank on a Wishbone-style slave port that two bus masters share. Each master has its own cycle, strobe, write-enable, address and write-data inputs, and its own acknowledge, error, retry and read-data outputs. A fixed-priority arbiter gives the bank to one master at a time. A registered one-hot grant vector shows which master holds it, and each master keeps its grant for as long as it holds its cycle line.

The bank holds three kinds of register on a 16-entry map with 8-bit data.
- Status registers are read only. They show values that other logic drives into the block.
- Setting registers can be read and written. They drive configuration outputs and load fixed values at reset.
- Trigger registers hold one bit each. A bus write sets the bit to start a process elsewhere, and that process clears the bit through a dedicated clear input when it finishes.

Top module: `csrb_bank`

## Requirements
- R1: After reset the three setting outputs are 0x05 (address 0x6, bits 7:0 of `setting_out`), 0x3C (address 0x7, bits 15:8) and 0xAA (address 0x8, bits 23:16). All trigger outputs are 0, `grant` is 0, and no acknowledge or error is asserted.
- R2: `grant` is always zero or one-hot, with bit i for master i. From idle, grant goes to the requesting master one clock after its `mst_cyc` rises. When both masters request in the same cycle, master 0 wins.
- R3: A granted master keeps its grant for as long as its `mst_cyc` stays high, even while the other master requests. The grant moves on the clock after `mst_cyc` drops.
- R4: An access takes place on the first clock edge at which the granted master has cyc and strobe high and no response was shown in the cycle before. Its response appears after that edge, lasts exactly one clock, and goes only to that master. A master's read data is 0 whenever its acknowledge is low.
- R5: A strobe to an unmapped address (0x3, 0x4, 0x5, 0x9, 0xD, 0xE or 0xF), or a write to a status address, returns error instead of acknowledge and changes no register. Retry is never asserted.
- R6: Reading status address 0x0, 0x1 or 0x2 returns the value on slice 0, 1 or 2 of `status_in` (bits 7:0, 15:8, 23:16) as it stands at the access edge.
- R7: Writing setting address 0x6, 0x7 or 0x8 stores the data. The data appears on the matching `setting_out` slice and is returned by later reads.
- R8: Writing trigger address 0xA, 0xB or 0xC (triggers 0, 1, 2) with data bit 0 set (value 0x01) sets the matching `trig_out` bit. The other data bits are ignored, and writing a 0 in bit 0 leaves the trigger unchanged. A read returns the trigger in bit 0 and 0 in bits 7:1.
- R9: A trigger stays set until its `trig_clr` bit is high at a clock edge, which clears it. If that clear and a setting bus write meet on the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_cyc | input | 2 | Cycle line, one bit per master |
| mst_stb | input | 2 | Strobe, one bit per master |
| mst_we | input | 2 | Write enable, one bit per master |
| mst_adr | input | 8 | Address, 4 bits per master (master i in bits 4i+3:4i) |
| mst_wdat | input | 16 | Write data, 8 bits per master |
| mst_ack | output | 2 | Acknowledge, per master |
| mst_err | output | 2 | Error response, per master |
| mst_rty | output | 2 | Retry response, per master (never asserted) |
| mst_rdat | output | 16 | Read data, 8 bits per master |
| grant | output | 2 | One-hot grant vector |
| status_in | input | 24 | Values shown by the three status registers |
| setting_out | output | 24 | Contents of the three setting registers |
| trig_out | output | 3 | Trigger bits |
| trig_clr | input | 3 | Per-trigger clear from the launched logic |

## Verification
The hardest case to reach from the ports is a trigger clear that lands on the same edge as a bus write setting that trigger. The write only takes effect two edges after the master raises its strobe. The bench therefore starts the write, waits one clock until the grant is visible, and only then raises the clear, so that both hit the access edge together. Holding the grant against a higher-priority request is reached the same way: the lower-priority master raises cycle with no strobe first, and the other master requests only after that grant is visible.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int NUM_MST   = 2;
    localparam int NUM_STAT  = 3;
    localparam int NUM_SET   = 3;
    localparam int NUM_TRIG  = 3;
    localparam int STAT_BASE = 0;
    localparam int SET_BASE  = 6;
    localparam int TRIG_BASE = 10;
    localparam int TRIG_BIT  = 0;
    localparam logic [NUM_SET*DATA_W-1:0] SET_RESET = 24'hAA3C05;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic [NUM_SET*DATA_W-1:0] setting;
        logic [NUM_TRIG-1:0]       trig;
    } reg_state_t;

    typedef struct packed {
        logic [NUM_MST-1:0] ack;
        logic [NUM_MST-1:0] err;
        data_t              rdat;
    } resp_state_t;
endpackage

// File: rtl/csrb_arbiter.sv
module csrb_arbiter
    import csrb_pkg::*;
#(
    parameter int N = NUM_MST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] grant_d, grant_q;

    always_comb begin
        grant_d = grant_q;
        if ((grant_q & req) == '0) begin
            grant_d = '0;
            // descending scan: lowest index is assigned last and wins
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) begin
                    grant_d    = '0;
                    grant_d[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant_q <= '0;
        else        grant_q <= grant_d;
    end

    assign grant = grant_q;
endmodule

// File: rtl/csrb_decode.sv
module csrb_decode
    import csrb_pkg::*;
(
    input  addr_t               adr,
    output logic [NUM_STAT-1:0] stat_hit,
    output logic [NUM_SET-1:0]  set_hit,
    output logic [NUM_TRIG-1:0] trig_hit,
    output logic                mapped
);
    for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
        assign stat_hit[i] = (adr == addr_t'(STAT_BASE + i));
    end
    for (genvar i = 0; i < NUM_SET; i++) begin : g_set
        assign set_hit[i] = (adr == addr_t'(SET_BASE + i));
    end
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
        assign trig_hit[i] = (adr == addr_t'(TRIG_BASE + i));
    end

    assign mapped = |{stat_hit, set_hit, trig_hit};
endmodule

// File: rtl/csrb_regs.sv
module csrb_regs
    import csrb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  data_t                      wdat,
    input  logic [NUM_STAT-1:0]        stat_hit,
    input  logic [NUM_SET-1:0]         set_hit,
    input  logic [NUM_TRIG-1:0]        trig_hit,
    input  logic [NUM_STAT*DATA_W-1:0] status_in,
    input  logic [NUM_TRIG-1:0]        trig_clr,
    output logic [NUM_SET*DATA_W-1:0]  setting,
    output logic [NUM_TRIG-1:0]        trig,
    output data_t                      rdata
);
    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SET; i++) begin
            if (wr_en && set_hit[i]) st_d.setting[i*DATA_W +: DATA_W] = wdat;
        end
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (trig_clr[i])                              st_d.trig[i] = 1'b0;
            else if (wr_en && trig_hit[i] && wdat[TRIG_BIT]) st_d.trig[i] = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_STAT; i++) begin
            if (stat_hit[i]) rdata = rdata | status_in[i*DATA_W +: DATA_W];
        end
        for (int i = 0; i < NUM_SET; i++) begin
            if (set_hit[i]) rdata = rdata | st_q.setting[i*DATA_W +: DATA_W];
        end
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (trig_hit[i]) rdata[TRIG_BIT] = rdata[TRIG_BIT] | st_q.trig[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.setting <= SET_RESET;
            st_q.trig    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign setting = st_q.setting;
    assign trig    = st_q.trig;
endmodule

// File: rtl/csrb_bank.sv
module csrb_bank
    import csrb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_MST-1:0]         mst_cyc,
    input  logic [NUM_MST-1:0]         mst_stb,
    input  logic [NUM_MST-1:0]         mst_we,
    input  logic [NUM_MST*ADDR_W-1:0]  mst_adr,
    input  logic [NUM_MST*DATA_W-1:0]  mst_wdat,
    output logic [NUM_MST-1:0]         mst_ack,
    output logic [NUM_MST-1:0]         mst_err,
    output logic [NUM_MST-1:0]         mst_rty,
    output logic [NUM_MST*DATA_W-1:0]  mst_rdat,
    output logic [NUM_MST-1:0]         grant,
    input  logic [NUM_STAT*DATA_W-1:0] status_in,
    output logic [NUM_SET*DATA_W-1:0]  setting_out,
    output logic [NUM_TRIG-1:0]        trig_out,
    input  logic [NUM_TRIG-1:0]        trig_clr
);
    logic                sel_stb, sel_we;
    addr_t               sel_adr;
    data_t               sel_wdat, rdata;
    logic [NUM_STAT-1:0] stat_hit;
    logic [NUM_SET-1:0]  set_hit;
    logic [NUM_TRIG-1:0] trig_hit;
    logic                mapped, pending, access, bad, wr_en;
    resp_state_t         rs_d, rs_q;

    csrb_arbiter #(.N(NUM_MST)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mst_cyc),
        .grant (grant)
    );

    // route the granted master's request onto the shared path
    always_comb begin
        sel_stb  = 1'b0;
        sel_we   = 1'b0;
        sel_adr  = '0;
        sel_wdat = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (grant[i]) begin
                sel_stb  = mst_cyc[i] & mst_stb[i];
                sel_we   = mst_we[i];
                sel_adr  = mst_adr[i*ADDR_W +: ADDR_W];
                sel_wdat = mst_wdat[i*DATA_W +: DATA_W];
            end
        end
    end

    csrb_decode u_dec (
        .adr      (sel_adr),
        .stat_hit (stat_hit),
        .set_hit  (set_hit),
        .trig_hit (trig_hit),
        .mapped   (mapped)
    );

    assign pending = (|rs_q.ack) | (|rs_q.err);
    assign access  = sel_stb & ~pending;
    assign bad     = ~mapped | (sel_we & (|stat_hit));
    assign wr_en   = access & sel_we & ~bad;

    csrb_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wdat      (sel_wdat),
        .stat_hit  (stat_hit),
        .set_hit   (set_hit),
        .trig_hit  (trig_hit),
        .status_in (status_in),
        .trig_clr  (trig_clr),
        .setting   (setting_out),
        .trig      (trig_out),
        .rdata     (rdata)
    );

    always_comb begin
        rs_d.ack  = (access && !bad) ? grant : '0;
        rs_d.err  = (access &&  bad) ? grant : '0;
        rs_d.rdat = (access && !bad && !sel_we) ? rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    for (genvar i = 0; i < NUM_MST; i++) begin : g_out
        assign mst_rdat[i*DATA_W +: DATA_W] = rs_q.ack[i] ? rs_q.rdat : '0;
    end
    assign mst_ack = rs_q.ack;
    assign mst_err = rs_q.err;
    assign mst_rty = '0;
endmodule

// File: rtl/csrb_bank_chk.sv
module csrb_bank_chk
    import csrb_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_MST-1:0]  mst_cyc,
    input logic [NUM_MST-1:0]  mst_ack,
    input logic [NUM_MST-1:0]  mst_err,
    input logic [NUM_MST-1:0]  grant,
    input logic [NUM_TRIG-1:0] trig_out,
    input logic [NUM_TRIG-1:0] trig_clr
);
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    for (genvar i = 0; i < NUM_MST; i++) begin : g_m
        a_r3_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && mst_cyc[i]) |=> grant[i]);
        a_r4_resp_to_holder: assert property (@(posedge clk) disable iff (!rst_n)
            (mst_ack[i] || mst_err[i]) |-> $past(grant[i]));
        a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (mst_ack[i] || mst_err[i]) |=> !(mst_ack[i] || mst_err[i]));
        a_r5_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(mst_ack[i] && mst_err[i]));
    end

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_t
        a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            trig_clr[t] |=> !trig_out[t]);
        a_r9_trig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_out[t] && !trig_clr[t]) |=> trig_out[t]);
    end
endmodule

bind csrb_bank csrb_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mst_cyc  (mst_cyc),
    .mst_ack  (mst_ack),
    .mst_err  (mst_err),
    .grant    (grant),
    .trig_out (trig_out),
    .trig_clr (trig_clr)
);

// File: tb/csrb_bank_bench.sv
module csrb_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mst_cyc = '0, mst_stb = '0, mst_we = '0;
    logic [7:0]  mst_adr = '0;
    logic [15:0] mst_wdat = '0;
    logic [1:0]  mst_ack, mst_err, mst_rty, grant;
    logic [15:0] mst_rdat;
    logic [23:0] status_in = '0;
    logic [23:0] setting_out;
    logic [2:0]  trig_out;
    logic [2:0]  trig_clr = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csrb_bank u_csrb_bank (
        .clk(clk), .rst_n(rst_n), .mst_cyc(mst_cyc), .mst_stb(mst_stb),
        .mst_we(mst_we), .mst_adr(mst_adr), .mst_wdat(mst_wdat),
        .mst_ack(mst_ack), .mst_err(mst_err), .mst_rty(mst_rty),
        .mst_rdat(mst_rdat), .grant(grant), .status_in(status_in),
        .setting_out(setting_out), .trig_out(trig_out), .trig_clr(trig_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int m, input logic we, input logic [3:0] a, input logic [7:0] wd);
        mst_cyc[m] = 1'b1; mst_stb[m] = 1'b1; mst_we[m] = we;
        mst_adr[m*4 +: 4] = a; mst_wdat[m*8 +: 8] = wd;
    endtask

    task automatic release_m(input int m);
        mst_cyc[m] = 1'b0; mst_stb[m] = 1'b0; mst_we[m] = 1'b0;
    endtask

    task automatic xfer(input int m, input logic we, input logic [3:0] a, input logic [7:0] wd,
                        output logic ack, output logic err, output logic [7:0] rd, output int lat);
        @(negedge clk);
        drive(m, we, a, wd);
        ack = 0; err = 0; rd = '0; lat = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (mst_ack[m] || mst_err[m]) begin
                ack = mst_ack[m]; err = mst_err[m]; rd = mst_rdat[m*8 +: 8]; lat = k;
                break;
            end
        end
        release_m(m);
    endtask

    task automatic t_reset();
        chk("R1 setting_out", setting_out, 24'hAA3C05);
        chk("R1 trig_out", trig_out, 0);
        chk("R1 grant", grant, 0);
        chk("R1 ack/err", {mst_ack, mst_err}, 0);
    endtask

    task automatic t_status_read();
        logic a, e; logic [7:0] d; int l;
        status_in = 24'h11C35A;
        xfer(0, 0, 4'h0, 0, a, e, d, l);
        chk("R4 latency", l, 2);
        chk("R6 status0", {a, e, d}, {2'b10, 8'h5A});
        xfer(1, 0, 4'h2, 0, a, e, d, l);
        chk("R6 status2 via m1", {a, e, d}, {2'b10, 8'h11});
        status_in[15:8] = 8'h7E;
        xfer(0, 0, 4'h1, 0, a, e, d, l);
        chk("R6 status1 live", d, 8'h7E);
    endtask

    task automatic t_settings();
        logic a, e; logic [7:0] d; int l;
        xfer(0, 0, 4'h7, 0, a, e, d, l);
        chk("R1 read default 0x7", d, 8'h3C);
        xfer(0, 1, 4'h6, 8'h77, a, e, d, l);
        chk("R7 write ack", {a, e}, 2'b10);
        chk("R7 setting_out slice0", setting_out[7:0], 8'h77);
        xfer(1, 1, 4'h8, 8'hC4, a, e, d, l);
        chk("R7 setting_out m1 write", setting_out, 24'hC43C77);
        xfer(1, 0, 4'h6, 0, a, e, d, l);
        chk("R7 readback", d, 8'h77);
    endtask

    task automatic t_errors();
        logic a, e; logic [7:0] d; int l;
        logic [3:0] bad_list [7] = '{4'h3, 4'h4, 4'h5, 4'h9, 4'hD, 4'hE, 4'hF};
        foreach (bad_list[i]) begin
            xfer(i % 2, 0, bad_list[i], 0, a, e, d, l);
            chk("R5 unmapped read err", {a, e, d}, {2'b01, 8'h00});
        end
        xfer(0, 1, 4'h0, 8'hFF, a, e, d, l);
        chk("R5 status write err", {a, e}, 2'b01);
        xfer(0, 0, 4'h0, 0, a, e, d, l);
        chk("R5 status unchanged", d, 8'h5A);
        xfer(1, 1, 4'h9, 8'h00, a, e, d, l);
        chk("R5 unmapped write err", {a, e}, 2'b01);
        chk("R5 nothing written", {setting_out, trig_out}, {24'hC43C77, 3'b000});
        chk("R5 rty never", mst_rty, 0);
    endtask

    task automatic t_triggers();
        logic a, e; logic [7:0] d; int l;
        xfer(0, 1, 4'hB, 8'hFE, a, e, d, l);
        chk("R8 bit0 clear write ignored", trig_out, 3'b000);
        xfer(0, 1, 4'hB, 8'h01, a, e, d, l);
        chk("R8 trigger1 set", trig_out, 3'b010);
        xfer(1, 0, 4'hB, 0, a, e, d, l);
        chk("R8 read trigger1", d, 8'h01);
        xfer(1, 0, 4'hC, 0, a, e, d, l);
        chk("R8 read idle trigger2", d, 8'h00);
        xfer(0, 1, 4'hB, 8'h00, a, e, d, l);
        repeat (3) @(negedge clk);
        chk("R9 trigger held", trig_out, 3'b010);
        trig_clr[1] = 1'b1;
        @(negedge clk);
        trig_clr[1] = 1'b0;
        chk("R9 trigger cleared", trig_out, 3'b000);
    endtask

    task automatic t_clear_collision();
        @(negedge clk);
        drive(0, 1, 4'hA, 8'h01);
        @(negedge clk);
        trig_clr[0] = 1'b1;
        @(negedge clk);
        trig_clr[0] = 1'b0;
        chk("R9 collision acked", mst_ack[0], 1'b1);
        chk("R9 clear wins", trig_out[0], 1'b0);
        release_m(0);
        @(negedge clk);
        chk("R9 stays clear", trig_out[0], 1'b0);
    endtask

    task automatic t_arbitration();
        @(negedge clk);
        drive(0, 0, 4'h6, 0);
        drive(1, 0, 4'h7, 0);
        @(negedge clk);
        chk("R2 priority grant", grant, 2'b01);
        @(negedge clk);
        chk("R4 only holder acked", mst_ack, 2'b01);
        chk("R4 m0 data", mst_rdat[7:0], 8'h77);
        chk("R4 idle m1 data zero", mst_rdat[15:8], 8'h00);
        release_m(0);
        @(negedge clk);
        chk("R3 grant moves", grant, 2'b10);
        chk("R4 one-cycle ack", mst_ack, 2'b00);
        @(negedge clk);
        chk("R4 m1 acked", {mst_ack, mst_rdat[15:8]}, {2'b10, 8'h3C});
        release_m(1);
        @(negedge clk);
    endtask

    task automatic t_hold();
        @(negedge clk);
        mst_cyc[1] = 1'b1;
        @(negedge clk);
        chk("R2 grant after cyc", grant, 2'b10);
        drive(0, 0, 4'h8, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3 grant held", {grant, mst_ack[0]}, {2'b10, 1'b0});
        end
        mst_cyc[1] = 1'b0;
        @(negedge clk);
        chk("R3 grant released", grant, 2'b01);
        @(negedge clk);
        chk("R3 waiting master served", {mst_ack[0], mst_rdat[7:0]}, {1'b1, 8'hC4});
        @(negedge clk);
        chk("R4 held strobe one ack", mst_ack[0], 1'b0);
        release_m(0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_read();
        t_settings();
        t_errors();
        t_triggers();
        t_clear_collision();
        t_arbitration();
        t_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule